// File: doc/BRIEF.md
# Serial Configuration Register Port

This block is a serial slave that lets an external host read and write a small on-chip configuration register file. A transaction opens when chip select falls. The host first shifts in a 16-bit instruction word, then moves one or more data bytes. The instruction word holds a read flag and a 15-bit starting address. After each data byte the register address steps by one, either up or down, so one transaction can cover a run of neighbouring registers.

A mode register at address 0x000 sets three things: the bit order (most or least significant bit first), the address step direction, and whether the link uses four wires or three. In three-wire mode a single shared data pin carries both directions. The serial pins are brought into the system clock domain and sampled there. Input bits are captured on serial clock rising edges. Read data is launched on falling edges.

Most registers take a written byte as soon as its last bit arrives. The oscillator tuning word and the phase offset are different: writes land in shadow copies. The values seen on the active outputs change only when the host sets an update bit. That bit copies the shadows to the active registers and then clears itself.

Top module: `serial_cfg_port`

## Requirements
- R1: Raising chip select and lowering it again restarts the link at the first instruction bit, whatever partial transfer was in progress.
- R2: The first 16 serial clock rising edges after chip select falls form the instruction word. Word bit 15 set means read and clear means write. Word bits 14:0 give the starting address.
- R3: Each group of 8 rising edges after the instruction is one data byte. After each byte the address steps by one, so N bytes reach N consecutive addresses.
- R4: Mode register 0x000 bit 5 or bit 2 set makes the address increment after each byte. With both clear (the reset state) it decrements.
- R5: A general register (addresses 0x008 to 0x00B, byte k on gp_o bits 8k+7:8k) keeps its old value until the last bit of its byte has arrived, and holds the new value right after that.
- R6: Writes to the tuning word (0x010 to 0x013, least significant byte first) and the phase offset (0x018 to 0x019) leave ftw_o and phase_o unchanged. Reading those addresses returns the written shadow value.
- R7: Writing a byte with bit 0 set to address 0x01F copies both shadows to ftw_o and phase_o. The bit then clears itself, so 0x01F reads back as 0.
- R8: Mode register bit 6 or bit 1 set selects least-significant-bit-first order for the instruction and data bits alike. With both clear, the most significant bit goes first.
- R9: Mode register bit 4 or bit 3 set selects three-wire mode. Input is then taken from sdio_i and read data is driven on sdio_o. sdio_oe_o is high only during the data phase of a read, and sdo_o stays low.
- R10: In a read, each data bit changes after a falling serial clock edge and is valid before the rising edge that follows. The first bit is valid before the first data-phase rising edge.
- R11: Reading an address with no register returns 0, and writing it changes no register.
- R12: After reset every register is zero, the mode is four-wire with most-significant-bit-first order and decrementing addresses, and no data output is driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sck_i | input | 1 | Serial clock from host |
| csn_i | input | 1 | Active-low chip select |
| sdi_i | input | 1 | Serial data in, four-wire mode |
| sdio_i | input | 1 | Shared data pin, input side |
| sdo_o | output | 1 | Serial data out, four-wire mode |
| sdio_o | output | 1 | Shared data pin, output side |
| sdio_oe_o | output | 1 | Shared data pin output enable |
| gp_o | output | 32 | General registers, 4 bytes |
| ftw_o | output | 32 | Active tuning word |
| phase_o | output | 16 | Active phase offset |

## Verification
The bench drives multi-byte writes and reads in the decrementing default and again after switching to incrementing. Seeing which general register receives which byte tells the two step directions apart and shows that the address is stepped rather than held. The same register traffic is then repeated with least-significant-bit-first order and in three-wire mode. Addresses and data are chosen so that a reversed bit order or the wrong input pin would hit a different register or return a different value. Tuning writes are read back before and after the update request, which separates shadow storage from the active copy. An aborted partial instruction followed by a normal write shows whether the framing restarts.

// File: rtl/spi_cfg_pkg.sv
package spi_cfg_pkg;
  localparam int ADDR_W = 15;
  typedef logic [ADDR_W-1:0] addr_t;

  localparam addr_t MODE_ADDR = 15'h000;
  localparam addr_t GP_BASE   = 15'h008;
  localparam addr_t FTW_BASE  = 15'h010;
  localparam addr_t PH_BASE   = 15'h018;
  localparam addr_t UPD_ADDR  = 15'h01F;
endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
  parameter int          W       = 4,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] stg_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni)
          if (!rst_ni) stg_q[s] <= RST_VAL;
          else         stg_q[s] <= d_i;
      end else begin : g_next
        always_ff @(posedge clk_i or negedge rst_ni)
          if (!rst_ni) stg_q[s] <= RST_VAL;
          else         stg_q[s] <= stg_q[s-1];
      end
    end
  endgenerate

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/spi_frame.sv
module spi_frame
  import spi_cfg_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cs_active_i,
  input  logic       sck_rise_i,
  input  logic       sck_fall_i,
  input  logic       din_i,
  input  logic       lsb_first_i,
  input  logic       incr_i,
  input  logic [7:0] rd_data_i,
  output addr_t      rd_addr_o,
  output logic       wr_en_o,
  output addr_t      wr_addr_o,
  output logic [7:0] wr_data_o,
  output logic       rd_phase_o,
  output logic       dout_o
);
  logic        instr_done_q, rnw_q, dout_q, wr_en_q;
  logic [3:0]  cnt_q;
  logic [15:0] sr_q;
  addr_t       addr_q, wr_addr_q;
  logic [7:0]  rd_byte_q, wr_data_q;
  logic [15:0] instr_w;
  logic [7:0]  byte_w;

  // word as it stands once the current bit is shifted in
  assign instr_w = lsb_first_i ? {din_i, sr_q[15:1]} : {sr_q[14:0], din_i};
  assign byte_w  = lsb_first_i ? {din_i, sr_q[15:9]} : {sr_q[6:0], din_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      instr_done_q <= 1'b0;
      rnw_q        <= 1'b0;
      cnt_q        <= '0;
      sr_q         <= '0;
      addr_q       <= '0;
      wr_addr_q    <= '0;
      wr_data_q    <= '0;
      wr_en_q      <= 1'b0;
      rd_byte_q    <= '0;
      dout_q       <= 1'b0;
    end else begin
      wr_en_q <= 1'b0;
      if (!cs_active_i) begin
        instr_done_q <= 1'b0;
        cnt_q        <= '0;
        dout_q       <= 1'b0;
      end else if (sck_rise_i) begin
        sr_q <= lsb_first_i ? {din_i, sr_q[15:1]} : {sr_q[14:0], din_i};
        if (!instr_done_q) begin
          cnt_q <= cnt_q + 4'd1;
          if (cnt_q == 4'd15) begin
            instr_done_q <= 1'b1;
            rnw_q        <= instr_w[15];
            addr_q       <= instr_w[14:0];
            cnt_q        <= '0;
          end
        end else if (cnt_q == 4'd7) begin
          cnt_q     <= '0;
          addr_q    <= incr_i ? addr_q + addr_t'(1) : addr_q - addr_t'(1);
          wr_addr_q <= addr_q;
          wr_data_q <= byte_w;
          wr_en_q   <= !rnw_q;
        end else begin
          cnt_q <= cnt_q + 4'd1;
        end
      end else if (sck_fall_i && instr_done_q && rnw_q) begin
        // launch next read bit; a fresh byte is fetched at its first bit
        if (cnt_q == 4'd0) begin
          rd_byte_q <= rd_data_i;
          dout_q    <= lsb_first_i ? rd_data_i[0] : rd_data_i[7];
        end else begin
          dout_q <= lsb_first_i ? rd_byte_q[cnt_q[2:0]] : rd_byte_q[3'd7 - cnt_q[2:0]];
        end
      end
    end
  end

  assign rd_addr_o  = addr_q;
  assign wr_en_o    = wr_en_q;
  assign wr_addr_o  = wr_addr_q;
  assign wr_data_o  = wr_data_q;
  assign rd_phase_o = cs_active_i && instr_done_q && rnw_q;
  assign dout_o     = dout_q;

  // R2
  instr_align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(instr_done_q) |-> (cnt_q == 4'd0));

  // R5
  wr_after_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_q |-> ($past(sck_rise_i) && $past(cs_active_i)));

  // R3
  addr_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_active_i && instr_done_q && sck_rise_i && cnt_q == 4'd7) |=> (addr_q != $past(addr_q)));
endmodule

// File: rtl/spi_regbank.sv
module spi_regbank
  import spi_cfg_pkg::*;
#(
  parameter int GP_REGS   = 4,
  parameter int FTW_BYTES = 4,
  parameter int PH_BYTES  = 2,
  localparam int GP_W  = 8 * GP_REGS,
  localparam int FTW_W = 8 * FTW_BYTES,
  localparam int PH_W  = 8 * PH_BYTES
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_en_i,
  input  addr_t           wr_addr_i,
  input  logic [7:0]      wr_data_i,
  input  addr_t           rd_addr_i,
  output logic [7:0]      rd_data_o,
  output logic            incr_o,
  output logic            lsb_first_o,
  output logic            three_wire_o,
  output logic [GP_W-1:0]  gp_o,
  output logic [FTW_W-1:0] ftw_o,
  output logic [PH_W-1:0]  phase_o
);
  logic [7:0]                 mode_q;
  logic [GP_REGS-1:0][7:0]    gp_q;
  logic [FTW_BYTES-1:0][7:0]  ftw_sh_q;
  logic [PH_BYTES-1:0][7:0]   ph_sh_q;
  logic [FTW_W-1:0]           ftw_act_q;
  logic [PH_W-1:0]            ph_act_q;
  logic                       upd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q   <= '0;
      gp_q     <= '0;
      ftw_sh_q <= '0;
      ph_sh_q  <= '0;
    end else if (wr_en_i) begin
      if (wr_addr_i == MODE_ADDR) mode_q <= wr_data_i;
      for (int i = 0; i < GP_REGS; i++)
        if (wr_addr_i == GP_BASE + addr_t'(i)) gp_q[i] <= wr_data_i;
      for (int i = 0; i < FTW_BYTES; i++)
        if (wr_addr_i == FTW_BASE + addr_t'(i)) ftw_sh_q[i] <= wr_data_i;
      for (int i = 0; i < PH_BYTES; i++)
        if (wr_addr_i == PH_BASE + addr_t'(i)) ph_sh_q[i] <= wr_data_i;
    end
  end

  // request set on write, commit and self-clear on the following cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      upd_q     <= 1'b0;
      ftw_act_q <= '0;
      ph_act_q  <= '0;
    end else if (upd_q) begin
      upd_q     <= 1'b0;
      ftw_act_q <= ftw_sh_q;
      ph_act_q  <= ph_sh_q;
    end else if (wr_en_i && wr_addr_i == UPD_ADDR && wr_data_i[0]) begin
      upd_q <= 1'b1;
    end
  end

  always_comb begin
    rd_data_o = '0;
    if (rd_addr_i == MODE_ADDR) rd_data_o = mode_q;
    if (rd_addr_i == UPD_ADDR)  rd_data_o = {7'b0, upd_q};
    for (int i = 0; i < GP_REGS; i++)
      if (rd_addr_i == GP_BASE + addr_t'(i)) rd_data_o = gp_q[i];
    for (int i = 0; i < FTW_BYTES; i++)
      if (rd_addr_i == FTW_BASE + addr_t'(i)) rd_data_o = ftw_sh_q[i];
    for (int i = 0; i < PH_BYTES; i++)
      if (rd_addr_i == PH_BASE + addr_t'(i)) rd_data_o = ph_sh_q[i];
  end

  // mode fields mirrored about the byte centre: same meaning in either order
  assign incr_o       = mode_q[5] | mode_q[2];
  assign lsb_first_o  = mode_q[6] | mode_q[1];
  assign three_wire_o = mode_q[4] | mode_q[3];
  assign gp_o         = gp_q;
  assign ftw_o        = ftw_act_q;
  assign phase_o      = ph_act_q;

  // R7
  tune_commit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_q |=> ((ftw_act_q == $past(ftw_sh_q)) && (ph_act_q == $past(ph_sh_q)) && !upd_q));

  // R6
  tune_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_q |=> ($stable(ftw_act_q) && $stable(ph_act_q)));
endmodule

// File: rtl/serial_cfg_port.sv
module serial_cfg_port
  import spi_cfg_pkg::*;
#(
  parameter int GP_REGS     = 4,
  parameter int FTW_BYTES   = 4,
  parameter int PH_BYTES    = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   sck_i,
  input  logic                   csn_i,
  input  logic                   sdi_i,
  input  logic                   sdio_i,
  output logic                   sdo_o,
  output logic                   sdio_o,
  output logic                   sdio_oe_o,
  output logic [8*GP_REGS-1:0]   gp_o,
  output logic [8*FTW_BYTES-1:0] ftw_o,
  output logic [8*PH_BYTES-1:0]  phase_o
);
  logic [3:0] pins_s;
  logic       sck_s, csn_s, sdi_s, sdio_s, sck_d_q;
  logic       sck_rise, sck_fall, din;
  logic       incr, lsb_first, three_wire;
  logic       wr_en, rd_phase, dout;
  addr_t      rd_addr, wr_addr;
  logic [7:0] rd_data, wr_data;

  spi_pin_sync #(.W(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b0010)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({sdio_i, sdi_i, csn_i, sck_i}),
    .q_o   (pins_s)
  );
  assign {sdio_s, sdi_s, csn_s, sck_s} = pins_s;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) sck_d_q <= 1'b0;
    else         sck_d_q <= sck_s;

  assign sck_rise = sck_s & ~sck_d_q;
  assign sck_fall = ~sck_s & sck_d_q;
  assign din      = three_wire ? sdio_s : sdi_s;

  spi_frame u_frame (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cs_active_i(!csn_s),
    .sck_rise_i (sck_rise),
    .sck_fall_i (sck_fall),
    .din_i      (din),
    .lsb_first_i(lsb_first),
    .incr_i     (incr),
    .rd_data_i  (rd_data),
    .rd_addr_o  (rd_addr),
    .wr_en_o    (wr_en),
    .wr_addr_o  (wr_addr),
    .wr_data_o  (wr_data),
    .rd_phase_o (rd_phase),
    .dout_o     (dout)
  );

  spi_regbank #(.GP_REGS(GP_REGS), .FTW_BYTES(FTW_BYTES), .PH_BYTES(PH_BYTES)) u_bank (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_en_i     (wr_en),
    .wr_addr_i   (wr_addr),
    .wr_data_i   (wr_data),
    .rd_addr_i   (rd_addr),
    .rd_data_o   (rd_data),
    .incr_o      (incr),
    .lsb_first_o (lsb_first),
    .three_wire_o(three_wire),
    .gp_o        (gp_o),
    .ftw_o       (ftw_o),
    .phase_o     (phase_o)
  );

  assign sdo_o     = rd_phase & ~three_wire & dout;
  assign sdio_o    = rd_phase & three_wire & dout;
  assign sdio_oe_o = rd_phase & three_wire;

  // R9
  oe_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sdio_oe_o) |-> $past(sck_rise));
endmodule

// File: tb/sim_serial_cfg_port.sv
module sim_serial_cfg_port;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 10;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic sck_i = 1'b0, csn_i = 1'b1, sdi_i = 1'b0, sdio_i = 1'b0;
  logic sdo_o, sdio_o, sdio_oe_o;
  logic [31:0] gp_o, ftw_o;
  logic [15:0] phase_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_cfg_port u0 (
    .clk_i(clk), .rst_ni(rst_ni), .sck_i(sck_i), .csn_i(csn_i),
    .sdi_i(sdi_i), .sdio_i(sdio_i), .sdo_o(sdo_o), .sdio_o(sdio_o),
    .sdio_oe_o(sdio_oe_o), .gp_o(gp_o), .ftw_o(ftw_o), .phase_o(phase_o)
  );

  int n_vec = 0, n_err = 0;
  bit done = 0;
  logic lsb_m = 0, three_m = 0;
  logic [7:0] tx_buf [16];
  logic [7:0] exp_q [$];
  string      req_q [$];
  logic [7:0] obs_q [$];
  bit oe_in_instr, sdo_seen;
  int oe_miss;
  bit probe_en = 0;
  int probe_lane;
  logic [7:0] probe_old, probe_new;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // monitor: pairs each observed read byte with the queued expectation
  always begin
    @(posedge clk);
    while (obs_q.size() > 0 && exp_q.size() > 0) begin
      logic [7:0] o, e;
      string r;
      o = obs_q.pop_front();
      e = exp_q.pop_front();
      r = req_q.pop_front();
      chk(r, {56'b0, o}, {56'b0, e});
    end
  end

  task automatic send_bit(input logic b, output logic rb, output logic oe);
    if (three_m) begin sdio_i = b; sdi_i = 1'b0; end
    else         begin sdi_i = b; sdio_i = 1'b0; end
    repeat (HALF) @(negedge clk);
    rb = three_m ? sdio_o : sdo_o;
    oe = sdio_oe_o;
    if (sdo_o && three_m) sdo_seen = 1;
    sck_i = 1'b1;
    repeat (HALF) @(negedge clk);
    sck_i = 1'b0;
  endtask

  // driver: for reads tx_buf holds the expected bytes, pushed to the scoreboard
  task automatic xfer(input logic rnw, input logic [14:0] a, input int n, input string req);
    logic [15:0] ins;
    logic rb, oe;
    logic [7:0] rx;
    ins = {rnw, a};
    oe_in_instr = 0; oe_miss = 0; sdo_seen = 0;
    csn_i = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int i = 0; i < 16; i++) begin
      send_bit(lsb_m ? ins[i] : ins[15-i], rb, oe);
      if (oe) oe_in_instr = 1;
    end
    for (int k = 0; k < n; k++) begin
      rx = '0;
      if (rnw) begin exp_q.push_back(tx_buf[k]); req_q.push_back(req); end
      for (int i = 0; i < 8; i++) begin
        int bi;
        bi = lsb_m ? i : 7 - i;
        send_bit(rnw ? 1'b0 : tx_buf[k][bi], rb, oe);
        rx[bi] = rb;
        if (rnw && three_m && !oe) oe_miss++;
        if (probe_en && k == 0 && i == 6)
          chk("R5 before last bit", {56'b0, gp_o[probe_lane*8 +: 8]}, {56'b0, probe_old});
        if (probe_en && k == 0 && i == 7)
          chk("R5 after last bit", {56'b0, gp_o[probe_lane*8 +: 8]}, {56'b0, probe_new});
      end
      if (rnw) obs_q.push_back(rx);
    end
    repeat (HALF) @(negedge clk);
    csn_i = 1'b1;
    sdi_i = 1'b0; sdio_i = 1'b0;
    repeat (2*HALF) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_err);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_vec++; n_err++;
    $display("FAIL watchdog all act=running exp=finished");
    finish_run();
  end

  initial begin
    logic rb, oe;
    repeat (5) @(negedge clk);
    rst_ni = 1'b1;
    repeat (5) @(negedge clk);

    // R12 reset state
    chk("R12 gp", {32'b0, gp_o}, 64'h0);
    chk("R12 ftw/phase", {16'b0, ftw_o, phase_o}, 64'h0);
    chk("R12 outputs", {61'b0, sdo_o, sdio_o, sdio_oe_o}, 64'h0);

    // R2 R3 R4 R5: decrementing 3-byte write from 0x00B, probe lane 3
    tx_buf[0] = 8'hA1; tx_buf[1] = 8'hB2; tx_buf[2] = 8'hC3;
    probe_en = 1; probe_lane = 3; probe_old = 8'h00; probe_new = 8'hA1;
    xfer(1'b0, 15'h00B, 3, "R3");
    probe_en = 0;
    chk("R4 decrement write", {32'b0, gp_o}, {32'b0, 32'hA1B2C300});

    // R10 R2 read back decrementing
    tx_buf[0] = 8'hA1; tx_buf[1] = 8'hB2; tx_buf[2] = 8'hC3;
    xfer(1'b1, 15'h00B, 3, "R10 decrement read");

    // R4 increment mode
    tx_buf[0] = 8'h24;
    xfer(1'b0, 15'h000, 1, "R4");
    tx_buf[0] = 8'h11; tx_buf[1] = 8'h22;
    xfer(1'b0, 15'h008, 2, "R4");
    chk("R4 increment write", {32'b0, gp_o}, {32'b0, 32'hA1B22211});
    tx_buf[0] = 8'h11; tx_buf[1] = 8'h22; tx_buf[2] = 8'hB2; tx_buf[3] = 8'hA1;
    xfer(1'b1, 15'h008, 4, "R4 increment read");
    tx_buf[0] = 8'h24;
    xfer(1'b1, 15'h000, 1, "R4 mode readback");

    // R11 unimplemented address
    tx_buf[0] = 8'hFF;
    xfer(1'b0, 15'h005, 1, "R11");
    chk("R11 write ignored", {32'b0, gp_o}, {32'b0, 32'hA1B22211});
    tx_buf[0] = 8'h00; tx_buf[1] = 8'h00;
    xfer(1'b1, 15'h004, 2, "R11 read zero");

    // R6 shadow tuning writes
    tx_buf[0] = 8'h78; tx_buf[1] = 8'h56; tx_buf[2] = 8'h34; tx_buf[3] = 8'h12;
    xfer(1'b0, 15'h010, 4, "R6");
    tx_buf[0] = 8'hCD; tx_buf[1] = 8'hAB;
    xfer(1'b0, 15'h018, 2, "R6");
    chk("R6 ftw held", {32'b0, ftw_o}, 64'h0);
    chk("R6 phase held", {48'b0, phase_o}, 64'h0);
    tx_buf[0] = 8'h78; tx_buf[1] = 8'h56; tx_buf[2] = 8'h34; tx_buf[3] = 8'h12;
    xfer(1'b1, 15'h010, 4, "R6 shadow read");

    // R7 update request
    tx_buf[0] = 8'h01;
    xfer(1'b0, 15'h01F, 1, "R7");
    chk("R7 ftw committed", {32'b0, ftw_o}, {32'b0, 32'h12345678});
    chk("R7 phase committed", {48'b0, phase_o}, {48'b0, 16'hABCD});
    tx_buf[0] = 8'h00;
    xfer(1'b1, 15'h01F, 1, "R7 self clear");

    // R1 abort a partial instruction, then a normal write
    csn_i = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int i = 0; i < 5; i++) send_bit(1'b1, rb, oe);
    csn_i = 1'b1;
    repeat (2*HALF) @(negedge clk);
    tx_buf[0] = 8'h5A;
    xfer(1'b0, 15'h008, 1, "R1");
    chk("R1 restart", {32'b0, gp_o}, {32'b0, 32'hA1B2225A});

    // R8 LSB-first (0x66 reads the same in either order)
    tx_buf[0] = 8'h66;
    xfer(1'b0, 15'h000, 1, "R8");
    lsb_m = 1;
    tx_buf[0] = 8'h3C;
    xfer(1'b0, 15'h009, 1, "R8");
    chk("R8 lsb write", {32'b0, gp_o}, {32'b0, 32'hA1B23C5A});
    tx_buf[0] = 8'h5A; tx_buf[1] = 8'h3C;
    xfer(1'b1, 15'h008, 2, "R8 lsb read");

    // R9 three-wire (0x7E symmetric)
    tx_buf[0] = 8'h7E;
    xfer(1'b0, 15'h000, 1, "R9");
    three_m = 1;
    tx_buf[0] = 8'h96;
    xfer(1'b0, 15'h00A, 1, "R9");
    chk("R9 write via shared pin", {32'b0, gp_o}, {32'b0, 32'hA1963C5A});
    tx_buf[0] = 8'h96;
    xfer(1'b1, 15'h00A, 1, "R9 read on shared pin");
    chk("R9 oe off in instruction", {63'b0, oe_in_instr}, 64'h0);
    chk("R9 oe on in read data", {32'b0, oe_miss}, 64'h0);
    chk("R9 sdo quiet", {63'b0, sdo_seen}, 64'h0);
    chk("R9 oe released", {63'b0, sdio_oe_o}, 64'h0);

    repeat (5) @(negedge clk);
    chk("R10 all reads observed", {32'b0, exp_q.size()}, 64'h0);
    finish_run();
  end
endmodule